// File: doc/BRIEF.md
# Pipeline Stage-Weight Correction

This block sits behind the analog core of a pipelined converter. Every clock the core hands over one decision bit from each of its fifteen stages. The bits do not arrive together: the decision for a given sample from stage k comes k clocks after the decision from stage 0. The block holds each bit back until all fifteen bits of one sample are lined up. It then forms the output code by adding a signed coefficient for every bit that is set, plus a signed offset term.

The coefficients are stored in a sixteen-entry register file. Calibration logic writes this file through an address, data and write-enable port, and only while a calibrate-mode input is high. The wide sum is rounded to a 12-bit straight-binary code and clamped into range. A range flag reports when clamping occurred. An active-low enable either drives the data pins or leaves them at high impedance. A new code is produced on every clock.

Top module: `bit_weight_corrector`

## Requirements
- R1: While reset is high, the data code and range flag clear to 0. Reset also loads the coefficient file with ideal binary weights: entry k (0..14) holds 2^(14-k) and entry 15 (the offset) holds 0.
- R2: `rawBits[k]` carries stage k's decision, and bit k of a sample arrives k clocks after bit 0. If bit 0 of a sample is captured at rising edge t, that sample's code and flag appear after rising edge t+16. A new sample is accepted on every clock.
- R3: Coefficients are signed 16-bit two's complement values in units of 1/8 LSB. Let S be entry 15 plus the entries k whose bit is set. The unclamped code is floor((S+4)/8).
- R4: An unclamped code above 4095 gives a code of 4095 with the range flag at 1.
- R5: An unclamped code below 0 gives a code of 0 with the range flag at 1.
- R6: An unclamped code in 0..4095 is output unchanged with the range flag at 0.
- R7: A write with `wrEn` and `calMode` both high at a rising edge stores `wrData` into entry `wrAddr`. Entry k (0..14) is stage k's weight and entry 15 is the offset. Every sum formed after that edge uses the new value.
- R8: A write strobe while `calMode` is low has no effect on any coefficient.
- R9: With `outEnN` high, `dataOut` is high impedance in the same cycle. With it low, `dataOut` drives the current code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| rawBits | input | 15 | One decision per stage, bit k from stage k |
| calMode | input | 1 | Opens the coefficient write port when high |
| wrEn | input | 1 | Coefficient write strobe |
| wrAddr | input | 4 | Coefficient entry: 0..14 stage weights, 15 offset |
| wrData | input | 16 | Signed coefficient value, 1/8 LSB units |
| outEnN | input | 1 | Active-low data output enable |
| dataOut | output | 12 | Corrected straight-binary code, tri-stated when disabled |
| rangeFlag | output | 1 | High when the code was clamped |

## Verification
The bench models the core as skewed: in each cycle, bit k comes from the sample k cycles older than bit 0. The code and flag for a sample are due after the sixteenth rising edge following the capture of its stage-0 bit. The bench samples on the falling edge and compares the result against the sample that was started seventeen loop iterations earlier. Coefficient writes complete before a stream begins, so every expected code is computed with one fixed set of coefficients. The output-enable result is combinational and is checked a fraction of a cycle after the enable changes.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  parameter int STAGES_DEF = 15;
  parameter int OUT_W_DEF  = 12;
  parameter int COEF_W_DEF = 16;
  parameter int FRAC_W_DEF = 3;

  typedef struct packed {
    logic coefWe;
    logic driveData;
  } bwcStrobes_t;
endpackage

// File: rtl/bwc_ctrl.sv
module bwc_ctrl
  import bwc_pkg::*;
(
  input  logic        calMode,
  input  logic        wrEn,
  input  logic        outEnN,
  output bwcStrobes_t strobes
);
  // write port is open only during calibration; pad drive follows the enable pin
  always_comb begin
    strobes.coefWe    = wrEn & calMode;
    strobes.driveData = ~outEnN;
  end
endmodule

// File: rtl/bwc_coef_bank.sv
module bwc_coef_bank
  import bwc_pkg::*;
#(
  parameter int NUM_STAGES = STAGES_DEF,
  parameter int OUT_W      = OUT_W_DEF,
  parameter int COEF_W     = COEF_W_DEF,
  parameter int FRAC_W     = FRAC_W_DEF,
  parameter int NUM_COEF   = NUM_STAGES + 1,
  parameter int ADDR_W     = $clog2(NUM_COEF)
)(
  input  logic                             clk,
  input  logic                             rst,
  input  bwcStrobes_t                      strobes,
  input  logic [ADDR_W-1:0]                wrAddr,
  input  logic [COEF_W-1:0]                wrData,
  output logic [NUM_COEF-1:0][COEF_W-1:0]  coefBank
);
  // ideal binary weight of stage k expressed in 1/2^FRAC_W LSB units
  function automatic logic [COEF_W-1:0] idealWeight(input int k);
    int sh;
    sh = OUT_W - 1 - k + FRAC_W;
    if (k >= NUM_STAGES) return '0;
    if (sh < 0) return '0;
    return COEF_W'(1) << sh;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_COEF; i++) coefBank[i] <= idealWeight(i);
    end else if (strobes.coefWe && (int'(wrAddr) < NUM_COEF)) begin
      coefBank[wrAddr] <= wrData;
    end
  end
endmodule

// File: rtl/bwc_datapath.sv
module bwc_datapath
  import bwc_pkg::*;
#(
  parameter int NUM_STAGES = STAGES_DEF,
  parameter int OUT_W      = OUT_W_DEF,
  parameter int COEF_W     = COEF_W_DEF,
  parameter int FRAC_W     = FRAC_W_DEF,
  parameter int NUM_COEF   = NUM_STAGES + 1,
  parameter int ACC_W      = COEF_W + $clog2(NUM_COEF)
)(
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_STAGES-1:0]           rawBits,
  input  logic [NUM_COEF-1:0][COEF_W-1:0] coefBank,
  output logic [OUT_W-1:0]                codeQ,
  output logic                            rangeQ
);
  localparam logic signed [ACC_W-1:0] HALF  = (FRAC_W > 0) ? (ACC_W'(1) << (FRAC_W - 1)) : '0;
  localparam logic signed [ACC_W-1:0] MAXS  = (ACC_W'(1) << OUT_W) - ACC_W'(1);
  localparam int                      OFF_I = NUM_COEF - 1;

  logic [NUM_STAGES-1:0]    rawQ;
  logic [NUM_STAGES-1:0]    aligned;
  logic signed [ACC_W-1:0]  sumNext, sumQ, rounded;
  logic [OUT_W-1:0]         codeNext;
  logic                     rangeNext;

  always_ff @(posedge clk) begin
    if (rst) rawQ <= '0;
    else     rawQ <= rawBits;
  end

  // stage k is late by k clocks, so it waits (NUM_STAGES-1-k) more
  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_skew
    localparam int D = NUM_STAGES - 1 - k;
    if (D == 0) begin : g_direct
      assign aligned[k] = rawQ[k];
    end else begin : g_chain
      logic [D-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) begin
          sh <= '0;
        end else begin
          sh[0] <= rawQ[k];
          for (int j = 1; j < D; j++) sh[j] <= sh[j-1];
        end
      end
      assign aligned[k] = sh[D-1];
    end
  end

  function automatic logic signed [ACC_W-1:0] sext(input logic [COEF_W-1:0] c);
    return {{(ACC_W-COEF_W){c[COEF_W-1]}}, c};
  endfunction

  always_comb begin
    sumNext = sext(coefBank[OFF_I]);
    for (int k = 0; k < NUM_STAGES; k++) begin
      if (aligned[k]) sumNext = sumNext + sext(coefBank[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sumQ <= '0;
    else     sumQ <= sumNext;
  end

  always_comb begin
    rounded = (sumQ + HALF) >>> FRAC_W;
    if (rounded < 0) begin
      codeNext  = '0;
      rangeNext = 1'b1;
    end else if (rounded > MAXS) begin
      codeNext  = '1;
      rangeNext = 1'b1;
    end else begin
      codeNext  = rounded[OUT_W-1:0];
      rangeNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      codeQ  <= '0;
      rangeQ <= 1'b0;
    end else begin
      codeQ  <= codeNext;
      rangeQ <= rangeNext;
    end
  end
endmodule

// File: rtl/bit_weight_corrector.sv
module bit_weight_corrector
  import bwc_pkg::*;
#(
  parameter int NUM_STAGES = STAGES_DEF,
  parameter int OUT_W      = OUT_W_DEF,
  parameter int COEF_W     = COEF_W_DEF,
  parameter int FRAC_W     = FRAC_W_DEF,
  parameter int ADDR_W     = $clog2(NUM_STAGES + 1)
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_STAGES-1:0] rawBits,
  input  logic                  calMode,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [COEF_W-1:0]     wrData,
  input  logic                  outEnN,
  output logic [OUT_W-1:0]      dataOut,
  output logic                  rangeFlag
);
  localparam int NUM_COEF = NUM_STAGES + 1;

  bwcStrobes_t                     strobes;
  logic [NUM_COEF-1:0][COEF_W-1:0] coefBank;
  logic [OUT_W-1:0]                codeQ;

  bwc_ctrl u_ctrl (
    .calMode (calMode),
    .wrEn    (wrEn),
    .outEnN  (outEnN),
    .strobes (strobes)
  );

  bwc_coef_bank #(
    .NUM_STAGES(NUM_STAGES), .OUT_W(OUT_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W),
    .NUM_COEF(NUM_COEF), .ADDR_W(ADDR_W)
  ) u_coef (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .coefBank (coefBank)
  );

  bwc_datapath #(
    .NUM_STAGES(NUM_STAGES), .OUT_W(OUT_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W),
    .NUM_COEF(NUM_COEF)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .rawBits  (rawBits),
    .coefBank (coefBank),
    .codeQ    (codeQ),
    .rangeQ   (rangeFlag)
  );

  assign dataOut = strobes.driveData ? codeQ : {OUT_W{1'bz}};
endmodule

// File: rtl/bit_weight_corrector_chk.sv
module bit_weight_corrector_chk
  import bwc_pkg::*;
#(
  parameter int NUM_STAGES = STAGES_DEF,
  parameter int OUT_W      = OUT_W_DEF,
  parameter int COEF_W     = COEF_W_DEF,
  parameter int NUM_COEF   = NUM_STAGES + 1,
  parameter int ADDR_W     = $clog2(NUM_COEF)
)(
  input logic                            clk,
  input logic                            rst,
  input logic                            calMode,
  input logic                            wrEn,
  input logic [ADDR_W-1:0]               wrAddr,
  input logic [COEF_W-1:0]               wrData,
  input logic                            outEnN,
  input logic [OUT_W-1:0]                dataOut,
  input logic                            rangeFlag,
  input logic [NUM_COEF-1:0][COEF_W-1:0] coefBank
);
  // R4 and R5: a raised flag only ever accompanies a rail code
  a_r4_flag_clamped: assert property (@(posedge clk) disable iff (rst)
    (rangeFlag && !outEnN) |-> (dataOut == '0 || dataOut == '1));

  a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wrEn && calMode) |=> (coefBank[$past(wrAddr)] == $past(wrData)));

  a_r8_locked_outside_cal: assert property (@(posedge clk) disable iff (rst)
    !calMode |=> $stable(coefBank));

  a_r9_drive_known: assert property (@(posedge clk) disable iff (rst)
    !outEnN |-> !$isunknown(dataOut));
endmodule

bind bit_weight_corrector bit_weight_corrector_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .calMode   (calMode),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .outEnN    (outEnN),
  .dataOut   (dataOut),
  .rangeFlag (rangeFlag),
  .coefBank  (coefBank)
);

// File: tb/bit_weight_corrector_tb.sv
`timescale 1ns/1ps
module bit_weight_corrector_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [14:0] rawBits;
  logic        calMode, wrEn, outEnN;
  logic [3:0]  wrAddr;
  logic [15:0] wrData;
  logic [11:0] dataOut;
  logic        rangeFlag;

  always #4 clk = ~clk;

  bit_weight_corrector u_dut (
    .clk(clk), .rst(rst), .rawBits(rawBits), .calMode(calMode), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .outEnN(outEnN), .dataOut(dataOut),
    .rangeFlag(rangeFlag)
  );

  int          nRun = 0, nFail = 0;
  bit          done = 1'b0;
  int          mdlCoef [16];
  logic [14:0] pat [0:63];
  int          patN;

  task automatic check(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] getPat(input int idx);
    if (idx < 0 || idx >= patN) return '0;
    return pat[idx];
  endfunction

  // R3: floor((offset + sum of set weights + 4) / 8)
  function automatic int rawRound(input logic [14:0] p);
    int s;
    s = mdlCoef[15];
    for (int k = 0; k < 15; k++) if (p[k]) s += mdlCoef[k];
    return (s + 4) >>> 3;
  endfunction

  task automatic writeCoef(input bit cm, input int a, input int d);
    @(negedge clk);
    calMode = cm; wrEn = 1'b1; wrAddr = 4'(a); wrData = 16'(d);
    @(negedge clk);
    calMode = 1'b0; wrEn = 1'b0;
    if (cm) mdlCoef[a] = int'($signed(16'(d)));
  endtask

  // R2: stage k of sample n is driven in cycle n+k; result read 17 iterations later
  task automatic runStream(input string tag);
    for (int i = 0; i < patN + 17; i++) begin
      @(negedge clk);
      if (i >= 17) begin
        int r, ec, ef;
        r  = rawRound(pat[i-17]);
        ec = (r < 0) ? 0 : (r > 4095) ? 4095 : r;
        ef = (r < 0 || r > 4095) ? 1 : 0;
        check(tag, int'(dataOut), ec);
        if (r > 4095)   check("R4 flag", int'(rangeFlag), ef);
        else if (r < 0) check("R5 flag", int'(rangeFlag), ef);
        else            check("R6 flag", int'(rangeFlag), ef);
      end
      for (int k = 0; k < 15; k++) begin
        logic [14:0] tp;
        tp = getPat(i - k);
        rawBits[k] = tp[k];
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; rawBits = '0; calMode = 1'b0; wrEn = 1'b0;
    wrAddr = '0; wrData = '0; outEnN = 1'b0;
    for (int k = 0; k < 15; k++) mdlCoef[k] = 1 << (14 - k);
    mdlCoef[15] = 0;
    repeat (3) @(negedge clk);
    check("R1 code", int'(dataOut), 0);
    check("R1 flag", int'(rangeFlag), 0);
    rst = 1'b0;

    // R1 ideal weights from reset, directed corners then random
    pat[0] = 15'h0000; pat[1] = 15'h7FFF; pat[2] = 15'h0001;
    pat[3] = 15'h4000; pat[4] = 15'h5555; pat[5] = 15'h7FFB;
    for (int n = 6; n < 48; n++) pat[n] = 15'($urandom);
    patN = 48;
    runStream("R1 R2 R3 code");

    // R7: calibrated redundant weights with a negative offset
    writeCoef(1'b1, 15, -40);
    for (int k = 0; k < 15; k++)
      writeCoef(1'b1, k, (1 << (14 - k)) + int'($urandom % 17) - 8);
    pat[0] = 15'h0000; pat[1] = 15'h7FFF; pat[2] = 15'h0001; pat[3] = 15'h0006;
    for (int n = 4; n < 40; n++) pat[n] = 15'($urandom);
    patN = 40;
    runStream("R2 R3 R7 code");

    // R8: write strobe without calibrate mode must not move stage 0 weight
    writeCoef(1'b0, 0, 0);
    writeCoef(1'b0, 15, 4000);
    pat[0] = 15'h0001; pat[1] = 15'h0000;
    for (int n = 2; n < 16; n++) pat[n] = 15'($urandom);
    patN = 16;
    runStream("R8 code");

    // R9: enable is combinational at the pins
    @(negedge clk);
    outEnN = 1'b1;
    #1;
    nRun++;
    if (dataOut !== 12'hzzz) begin
      nFail++;
      $display("FAIL R9 actual=%h expected=zzz", dataOut);
    end
    outEnN = 1'b0;
    #1;
    begin
      int r;
      r = rawRound(15'h0000);
      check("R9 drive", int'(dataOut), (r < 0) ? 0 : (r > 4095) ? 4095 : r);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule